// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block generates the periodic interrupt tick of a PC-style real-time clock. The design is clocked by the system clock. A one-cycle enable, `ref_tick`, marks each edge of a 32.768 kHz reference. A free-running prescaler counts those enables. The block raises a one-cycle pulse each time the selected power-of-two period ends. The interrupt flag logic downstream uses that pulse to set its periodic flag. The flag is set whether or not the periodic interrupt is enabled.

An 8-bit frequency-select register is written through a simple write strobe and is always visible on a read-back port. Its low nibble is the rate code. Code 0 silences the tick. A nonzero code n gives 2^(16-n) Hz, which is a period of 2^(n-1) reference enables. The upper nibble is kept only for software; it has no effect on the tick. The prescaler is never cleared on a rewrite. As a result, a code change cannot produce a short or split pulse. Every pulse falls on a multiple of the new period, counted from reset.

Top module: `rtc_periodic_rate`

## Requirements
- R1: While reset is held, `rd_fsel` reads 0x26 and `periodic_pulse` is low.
- R2: With rate code 0 (bits 3:0 of the register), `periodic_pulse` never goes high.
- R3: With a constant nonzero rate code n, consecutive pulses are exactly 2^(n-1) reference enables apart. Code 1 pulses on every enable; code 15 pulses every 16384 enables.
- R4: A pulse appears only in the cycle right after a cycle in which `ref_tick` was high. While `ref_tick` stays low, no pulse occurs.
- R5: After reset, using the default code 6, the first pulse follows the 32nd reference enable and the next one follows the 64th (1024 Hz).
- R6: A write with `wr_en` high is visible on `rd_fsel` in the following cycle. Bits 7:4 are stored and read back but do not change the pulse spacing.
- R7: The prescaler counts every enable since reset. Each pulse under code n occurs when that count is a multiple of 2^(n-1). After a code change, the first pulse at the new rate comes no more than one new period of enables after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle enable per 32.768 kHz reference period |
| wr_en | input | 1 | Write strobe for the frequency-select register |
| wr_data | input | 8 | Write data; bits 3:0 are the rate code, bits 7:4 are stored only |
| rd_fsel | output | 8 | Current register contents |
| periodic_pulse | output | 1 | One-cycle tick that sets the periodic flag |

## Verification
A write is captured at the next clock edge and is seen on `rd_fsel` one cycle later. A pulse is registered: it appears one cycle after the edge that sampled the final `ref_tick` of a period, and it reflects the rate code held before that edge. At each falling edge the bench first adds the enable that the previous rising edge sampled, and then reads the pulse. It attributes each pulse to the code mirrored before that edge. Spacing, alignment and post-write latency are therefore all measured in counted enables, not in clock cycles, whether the enable is held high or toggled.

// File: rtl/rtcpi_pkg.sv
package rtcpi_pkg;
    localparam int CODE_W    = 4;
    localparam int FSEL_W    = 8;
    localparam int UPPER_W   = FSEL_W - CODE_W;
    localparam int NUM_CODES = 1 << CODE_W;
    // The slowest code needs a carry out of bit NUM_CODES-3.
    localparam int CNT_W     = NUM_CODES - 2;
    localparam logic [FSEL_W-1:0] FSEL_RESET = 8'h26;

    typedef struct packed {
        logic [UPPER_W-1:0] upper;
        logic [CODE_W-1:0]  code;
    } fsel_t;
endpackage

// File: rtl/rtcpi_fsel_reg.sv
module rtcpi_fsel_reg
    import rtcpi_pkg::*;
#(
    parameter logic [FSEL_W-1:0] RST_VAL = FSEL_RESET
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [FSEL_W-1:0] wr_data,
    output fsel_t             fsel
);
    typedef struct packed {
        fsel_t fsel;
    } reg_st_t;

    reg_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.fsel = fsel_t'(wr_data);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.fsel <= fsel_t'(RST_VAL);
        end else begin
            s_q <= s_d;
        end
    end

    assign fsel = s_q.fsel;
endmodule

// File: rtl/rtcpi_prescaler.sv
module rtcpi_prescaler
    import rtcpi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    output logic [CNT_W-1:0] cnt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_st_t;

    pre_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (ref_tick) begin
            s_d.cnt = s_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt = s_q.cnt;
endmodule

// File: rtl/rtcpi_rate_match.sv
module rtcpi_rate_match
    import rtcpi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic [CODE_W-1:0] code,
    input  logic [CNT_W-1:0]  cnt,
    output logic              pulse
);
    // Per code: the low counter bits that must all be one on the last enable.
    logic [CNT_W-1:0] mask_tbl [NUM_CODES];

    for (genvar k = 0; k < NUM_CODES; k++) begin : g_mask
        if (k == 0) begin : g_off
            assign mask_tbl[k] = '0;
        end else begin : g_on
            assign mask_tbl[k] = CNT_W'((64'd1 << (k - 1)) - 64'd1);
        end
    end

    typedef struct packed {
        logic pulse;
    } match_st_t;

    match_st_t s_d, s_q;
    logic [CNT_W-1:0] sel_mask;
    logic             period_end;

    always_comb begin
        sel_mask   = mask_tbl[code];
        period_end = (code != '0) && ((cnt & sel_mask) == sel_mask);
        s_d        = s_q;
        s_d.pulse  = ref_tick && period_end;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.pulse <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pulse = s_q.pulse;
endmodule

// File: rtl/rtc_periodic_rate.sv
module rtc_periodic_rate
    import rtcpi_pkg::*;
#(
    parameter logic [FSEL_W-1:0] RESET_FSEL = FSEL_RESET
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              wr_en,
    input  logic [FSEL_W-1:0] wr_data,
    output logic [FSEL_W-1:0] rd_fsel,
    output logic              periodic_pulse
);
    fsel_t            fsel;
    logic [CNT_W-1:0] cnt;

    rtcpi_fsel_reg #(.RST_VAL(RESET_FSEL)) u_fsel (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .fsel    (fsel)
    );

    rtcpi_prescaler u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .cnt      (cnt)
    );

    rtcpi_rate_match u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .code     (fsel.code),
        .cnt      (cnt),
        .pulse    (periodic_pulse)
    );

    assign rd_fsel = fsel;
endmodule

// File: rtl/rtc_periodic_rate_chk.sv
module rtc_periodic_rate_chk
    import rtcpi_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ref_tick,
    input logic              wr_en,
    input logic [FSEL_W-1:0] wr_data,
    input logic [FSEL_W-1:0] rd_fsel,
    input logic              periodic_pulse
);
    // Enables seen since the last pulse; a pulse cycle restarts the count.
    logic [15:0]       refs_q;
    logic              clean_q;
    logic [CODE_W-1:0] code_prev_q;
    logic              code_change;
    logic [15:0]       exp_gap;

    assign code_change = wr_en && (wr_data[CODE_W-1:0] != rd_fsel[CODE_W-1:0]);
    assign exp_gap     = 16'd1 << (code_prev_q - CODE_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            refs_q      <= '0;
            clean_q     <= 1'b1;
            code_prev_q <= FSEL_RESET[CODE_W-1:0];
        end else begin
            refs_q      <= (periodic_pulse ? 16'd0 : refs_q) + {15'd0, ref_tick};
            code_prev_q <= rd_fsel[CODE_W-1:0];
            if (code_change) begin
                clean_q <= 1'b0;
            end else if (periodic_pulse && code_prev_q == rd_fsel[CODE_W-1:0]) begin
                clean_q <= 1'b1;
            end
        end
    end

    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (rd_fsel == FSEL_RESET && !periodic_pulse));

    a_r2_code_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fsel[CODE_W-1:0] == '0) |=> !periodic_pulse);

    a_r3_exact_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (periodic_pulse && clean_q && code_prev_q != '0) |-> (refs_q == exp_gap));

    a_r4_pulse_after_ref: assert property (@(posedge clk) disable iff (!rst_n)
        periodic_pulse |-> $past(ref_tick));

    a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_fsel == $past(wr_data)));

    a_r6_reg_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_fsel));
endmodule

bind rtc_periodic_rate rtc_periodic_rate_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ref_tick       (ref_tick),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .rd_fsel        (rd_fsel),
    .periodic_pulse (periodic_pulse)
);

// File: tb/rtc_periodic_rate_tb.sv
module rtc_periodic_rate_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_fsel;
    logic       periodic_pulse;

    always #4 clk = ~clk;

    rtc_periodic_rate u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .ref_tick       (ref_tick),
        .wr_en          (wr_en),
        .wr_data        (wr_data),
        .rd_fsel        (rd_fsel),
        .periodic_pulse (periodic_pulse)
    );

    // Entry: {upper nibble, rate code, reference mode}; mode 0 = every cycle, 1 = every other cycle
    localparam logic [9:0] VEC [16] = '{
        {4'h2, 4'd0,  2'd0}, {4'h0, 4'd1,  2'd1}, {4'hF, 4'd2,  2'd0}, {4'h5, 4'd3,  2'd1},
        {4'hA, 4'd4,  2'd0}, {4'h3, 4'd5,  2'd1}, {4'h2, 4'd6,  2'd0}, {4'h7, 4'd7,  2'd1},
        {4'h1, 4'd8,  2'd0}, {4'hC, 4'd9,  2'd1}, {4'h0, 4'd10, 2'd0}, {4'h9, 4'd11, 2'd0},
        {4'h6, 4'd12, 2'd0}, {4'hE, 4'd13, 2'd0}, {4'h4, 4'd14, 2'd0}, {4'hB, 4'd15, 2'd0}
    };

    int n_chk = 0;
    int n_bad = 0;
    int ref_total = 0;
    int ref_mode = 0;
    bit ref_phase = 1'b0;
    logic [7:0] mirror = 8'h26;
    bit   got_pulse;
    int   got_ref;
    int   got_code;
    bit   finished = 1'b0;

    function automatic int period(int c);
        return 1 << (c - 1);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // One cycle: account the sampled enable, look at the pulse, then drive the next inputs.
    task automatic step();
        int used;
        @(negedge clk);
        if (rst_n && ref_tick) ref_total++;
        used      = int'(mirror[3:0]);
        got_pulse = periodic_pulse;
        got_ref   = ref_total;
        got_code  = used;
        if (periodic_pulse) begin
            check(ref_tick == 1'b1, "R4 pulse without preceding enable", int'(ref_tick), 1);
            if (used == 0) begin
                check(1'b0, "R2 pulse under code 0", 1, 0);
            end else begin
                check(ref_total % period(used) == 0, "R7 pulse alignment (ref count mod period)",
                      ref_total % period(used), 0);
            end
        end
        if (wr_en) mirror = wr_data;
        wr_en = 1'b0;
        case (ref_mode)
            0: ref_tick = 1'b1;
            1: begin ref_phase = ~ref_phase; ref_tick = ref_phase; end
            default: ref_tick = 1'b0;
        endcase
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; ref_tick = 1'b0;
        repeat (3) @(negedge clk);
        check(rd_fsel == 8'h26, "R1 reset register value", int'(rd_fsel), 'h26);
        check(periodic_pulse == 1'b0, "R1 pulse low in reset", int'(periodic_pulse), 0);
        ref_total = 0;
        mirror    = 8'h26;
        ref_phase = 1'b0;
        rst_n     = 1'b1;
        ref_tick  = (ref_mode == 0);
    endtask

    task automatic run_entry(logic [3:0] up, logic [3:0] code, int mode);
        int wref, prev, found, limit, cnt0;
        ref_mode = mode;
        wr_en    = 1'b1;
        wr_data  = {up, code};
        step();
        step();
        check(rd_fsel == {up, code}, "R6 read back after write", int'(rd_fsel), int'({up, code}));
        wref = ref_total - (got_pulse ? 0 : 0);
        if (code == 4'd0) begin
            cnt0 = 0;
            for (int i = 0; i < 300; i++) begin
                step();
                if (got_pulse) cnt0++;
            end
            check(cnt0 == 0, "R2 no pulses with code 0", cnt0, 0);
        end else begin
            found = 0;
            prev  = 0;
            limit = period(int'(code)) * 4 * (mode == 1 ? 2 : 1) + 16;
            for (int i = 0; i < limit && found < 3; i++) begin
                step();
                if (got_pulse && got_code == int'(code)) begin
                    if (found == 0) begin
                        check(got_ref - wref <= period(int'(code)), "R7 first pulse latency after write",
                              got_ref - wref, period(int'(code)));
                    end else begin
                        check(got_ref - prev == period(int'(code)), "R3 pulse spacing (R6 upper bits inert)",
                              got_ref - prev, period(int'(code)));
                    end
                    prev = got_ref;
                    found++;
                end
            end
            check(found == 3, "R3 pulses observed", found, 3);
        end
    endtask

    initial begin
        repeat (199000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int found, cnt;
        int pos [2];
        // R5: default rate straight out of reset
        ref_mode = 0;
        do_reset();
        found = 0;
        for (int i = 0; i < 200 && found < 2; i++) begin
            step();
            if (got_pulse) begin pos[found] = got_ref; found++; end
        end
        check(found == 2, "R5 pulses after reset", found, 2);
        check(pos[0] == 32, "R5 first pulse at enable 32", pos[0], 32);
        check(pos[1] == 64, "R5 second pulse at enable 64", pos[1], 64);

        // R2, R3, R6, R7: every code from the table
        for (int v = 0; v < 16; v++) begin
            run_entry(VEC[v][9:6], VEC[v][5:2], int'(VEC[v][1:0]));
        end

        // R4: enable held low means no pulses, even at the fastest code
        ref_mode = 2;
        wr_en = 1'b1; wr_data = 8'h01;
        step(); step();
        cnt = 0;
        for (int i = 0; i < 60; i++) begin
            step();
            if (got_pulse) cnt++;
        end
        check(cnt == 0, "R4 silent while enable low", cnt, 0);
        ref_mode = 0;
        step(); step();
        check(got_pulse == 1'b1, "R4 pulse resumes with enable", int'(got_pulse), 1);

        // R1: reset again mid-run restores the default register
        wr_en = 1'b1; wr_data = 8'hF3;
        step();
        do_reset();
        step();
        check(rd_fsel == 8'h26, "R1 register after second reset", int'(rd_fsel), 'h26);
        finish_run();
    end
endmodule